// File: doc/BRIEF.md
# Command-Line Turnaround Spacing Controller

This block sits inside a memory-card host controller and guards the shared, bidirectional command line. It watches single-cycle strobes marking the moment a host command or a card response has finished on the wire. It holds back permission to start the next command until the spacing needed after that event has elapsed. The spacing depends on what happened last. A card response needs a short gap. A host command that expects no reply needs a short gap too. An identification command that drew no answer from any card needs the short gap plus 136 extra cycles. That extra allowance covers the longest response a card might still have been sending.

A command that does expect a reply leaves the line busy until the reply's end strobe arrives, and the response spacing then runs. Each new end strobe discards any spacing still in progress and starts over with the rule for the newest event. Command serialization and response decoding belong to neighbouring blocks. This block only times the gaps and drives one permission output.

Top module: `cmdgap_top`

## Requirements
- R1: In the first cycle after reset is released, with no end strobe present, `issue_ok_o` is high.
- R2: In any cycle where `cmd_done_i` or `rsp_done_i` is high, `issue_ok_o` is low in that same cycle.
- R3: After a response end strobe in cycle t (with `cmd_done_i` low), `issue_ok_o` is low in cycles t to t+RSP_GAP-1 and high in cycle t+RSP_GAP (8 with default parameters).
- R4: After a command end strobe with `no_rsp_i`=1 and `acq_silent_i`=0 in cycle t, `issue_ok_o` first returns high in cycle t+CMD_GAP (8 by default).
- R5: After a command end strobe with `no_rsp_i`=1 and `acq_silent_i`=1 in cycle t, `issue_ok_o` first returns high in cycle t+CMD_GAP+LONG_RSP_LEN (144 by default).
- R6: After a command end strobe with `no_rsp_i`=0, `issue_ok_o` stays low for as long as no further strobe arrives. A later response end strobe then starts the R3 spacing.
- R7: A new end strobe that arrives while spacing is still running restarts the count, using the gap for the newest event.
- R8: When `cmd_done_i` and `rsp_done_i` are high in the same cycle, the command-end rule applies.
- R9: `acq_silent_i` has no effect unless `cmd_done_i`=1 and `no_rsp_i`=1. A response end strobe always gives RSP_GAP.
- R10: With no strobes, `issue_ok_o` stays high once it has returned high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock; one cycle is one command-line bit period |
| rst | input | 1 | Synchronous active-high reset |
| cmd_done_i | input | 1 | One-cycle strobe: a host command's end bit has just been sent |
| rsp_done_i | input | 1 | One-cycle strobe: a card response's end bit has just been received |
| no_rsp_i | input | 1 | Qualifies `cmd_done_i`: the finished command expects no reply |
| acq_silent_i | input | 1 | Qualifies `cmd_done_i`: it was an identification command that no card answered |
| issue_ok_o | output | 1 | High when the next host command may begin |

## Verification
The bench builds the block with its default values: RSP_GAP = 8, CMD_GAP = 8 and LONG_RSP_LEN = 136. These give a derived counter width of 8 bits. With these values the full 144-cycle silent-identification window fits easily within the run. It can be measured edge to edge, and a counter width of one bit less would be exposed when the count cannot reach it. The equal short gaps mean that a response strobe and a quiet command strobe are told apart only through the awaiting-reply and simultaneous-strobe cases. The bench therefore aims those scenarios at that difference.

// File: rtl/cmdgap_pkg.sv
package cmdgap_pkg;

    // Kind of bus event that closed the most recent line activity.
    typedef enum logic [2:0] {
        EV_NONE           = 3'd0,
        EV_CMD_QUIET      = 3'd1,
        EV_CMD_ACQ_SILENT = 3'd2,
        EV_CMD_AWAIT      = 3'd3,
        EV_RSP            = 3'd4
    } bus_event_e;

    // Ownership state of the shared command line.
    typedef enum logic [1:0] {
        LINE_FREE      = 2'd0,
        LINE_AWAIT_RSP = 2'd1,
        LINE_SPACING   = 2'd2
    } line_state_e;

    // Gap in cycles demanded after a given event kind.
    function automatic int unsigned gap_for(
        input bus_event_e  ev,
        input int unsigned rsp_gap,
        input int unsigned cmd_gap,
        input int unsigned long_len
    );
        case (ev)
            EV_CMD_QUIET:      return cmd_gap;
            EV_CMD_ACQ_SILENT: return cmd_gap + long_len;
            EV_RSP:            return rsp_gap;
            default:           return 0;
        endcase
    endfunction

    // Largest gap any event may demand; sizes the counter.
    function automatic int unsigned max_gap(
        input int unsigned rsp_gap,
        input int unsigned cmd_gap,
        input int unsigned long_len
    );
        int unsigned cmd_worst;
        cmd_worst = cmd_gap + long_len;
        return (cmd_worst > rsp_gap) ? cmd_worst : rsp_gap;
    endfunction

endpackage

// File: rtl/cmdgap_event_classify.sv
module cmdgap_event_classify
    import cmdgap_pkg::*;
#(
    parameter int unsigned RSP_GAP      = 8,
    parameter int unsigned CMD_GAP      = 8,
    parameter int unsigned LONG_RSP_LEN = 136,
    parameter int unsigned GAP_W        = 8
) (
    input  logic             cmd_done,
    input  logic             rsp_done,
    input  logic             no_rsp,
    input  logic             acq_silent,
    output bus_event_e       ev_o,
    output logic [GAP_W-1:0] gap_o
);

    // A command end outranks a simultaneous response end (R8).
    // The silent flag only counts for a command expecting no reply (R9).
    always_comb begin
        ev_o = EV_NONE;
        if (cmd_done) begin
            if (!no_rsp)        ev_o = EV_CMD_AWAIT;
            else if (acq_silent) ev_o = EV_CMD_ACQ_SILENT;
            else                 ev_o = EV_CMD_QUIET;
        end else if (rsp_done) begin
            ev_o = EV_RSP;
        end
    end

    always_comb begin
        gap_o = GAP_W'(gap_for(ev_o, RSP_GAP, CMD_GAP, LONG_RSP_LEN));
    end

endmodule

// File: rtl/cmdgap_elapsed_counter.sv
module cmdgap_elapsed_counter #(
    parameter int unsigned GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [GAP_W-1:0] limit_i,
    output logic             reached_o
);

    logic [GAP_W-1:0] elapsed_q;

    // The strobe cycle itself is the first cycle of the gap, so a restart
    // loads one. The count saturates at the limit.
    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed_q <= '0;
        end else if (restart) begin
            elapsed_q <= GAP_W'(1);
        end else if (elapsed_q < limit_i) begin
            elapsed_q <= elapsed_q + GAP_W'(1);
        end
    end

    assign reached_o = (elapsed_q >= limit_i);

    // R7: a restart always brings the count back to its first step.
    assert_restart_reloads_R7: assert property (@(posedge clk) disable iff (rst)
        restart |=> (elapsed_q == GAP_W'(1)));

    // R5: the count never runs past the limit it was given.
    assert_no_overrun_R5: assert property (@(posedge clk) disable iff (rst)
        (elapsed_q <= limit_i) || $past(restart));

endmodule

// File: rtl/cmdgap_line_tracker.sv
module cmdgap_line_tracker
    import cmdgap_pkg::*;
#(
    parameter int unsigned GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_event_e       ev_i,
    input  logic [GAP_W-1:0] gap_i,
    input  logic             reached_i,
    output logic             restart_o,
    output logic [GAP_W-1:0] limit_o,
    output logic             ready_o
);

    line_state_e      state_q;
    logic [GAP_W-1:0] limit_q;
    logic             any_ev;

    assign any_ev    = (ev_i != EV_NONE);
    assign restart_o = (ev_i == EV_CMD_QUIET) || (ev_i == EV_CMD_ACQ_SILENT) ||
                       (ev_i == EV_RSP);
    assign limit_o   = limit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LINE_FREE;
            limit_q <= '0;
        end else begin
            unique case (ev_i)
                EV_CMD_AWAIT: state_q <= LINE_AWAIT_RSP;
                EV_CMD_QUIET, EV_CMD_ACQ_SILENT, EV_RSP: begin
                    state_q <= LINE_SPACING;
                    limit_q <= gap_i;
                end
                default: begin
                    if (state_q == LINE_SPACING && reached_i)
                        state_q <= LINE_FREE;
                end
            endcase
        end
    end

    assign ready_o = !any_ev &&
                     ((state_q == LINE_FREE) ||
                      (state_q == LINE_SPACING && reached_i));

    // R6: while a reply is awaited, the line stays closed without a new strobe.
    assert_await_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == LINE_AWAIT_RSP && !any_ev) |=> !ready_o || any_ev);

    // R1: the first quiet cycle after reset grants the line.
    assert_free_after_reset_R1: assert property (@(posedge clk)
        ($past(rst) && !rst && !any_ev) |-> ready_o);

endmodule

// File: rtl/cmdgap_top.sv
module cmdgap_top
    import cmdgap_pkg::*;
#(
    parameter int unsigned RSP_GAP      = 8,
    parameter int unsigned CMD_GAP      = 8,
    parameter int unsigned LONG_RSP_LEN = 136
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_done_i,
    input  logic rsp_done_i,
    input  logic no_rsp_i,
    input  logic acq_silent_i,
    output logic issue_ok_o
);

    localparam int unsigned WORST_GAP = max_gap(RSP_GAP, CMD_GAP, LONG_RSP_LEN);
    localparam int unsigned GAP_W     = $clog2(WORST_GAP + 1);

    bus_event_e       ev;
    logic [GAP_W-1:0] gap;
    logic [GAP_W-1:0] limit;
    logic             restart;
    logic             reached;

    cmdgap_event_classify #(
        .RSP_GAP      (RSP_GAP),
        .CMD_GAP      (CMD_GAP),
        .LONG_RSP_LEN (LONG_RSP_LEN),
        .GAP_W        (GAP_W)
    ) u_classify (
        .cmd_done   (cmd_done_i),
        .rsp_done   (rsp_done_i),
        .no_rsp     (no_rsp_i),
        .acq_silent (acq_silent_i),
        .ev_o       (ev),
        .gap_o      (gap)
    );

    cmdgap_line_tracker #(
        .GAP_W (GAP_W)
    ) u_tracker (
        .clk       (clk),
        .rst       (rst),
        .ev_i      (ev),
        .gap_i     (gap),
        .reached_i (reached),
        .restart_o (restart),
        .limit_o   (limit),
        .ready_o   (issue_ok_o)
    );

    cmdgap_elapsed_counter #(
        .GAP_W (GAP_W)
    ) u_counter (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .limit_i   (limit),
        .reached_o (reached)
    );

    // R2: any end strobe at the ports closes the line in that very cycle.
    assert_closed_on_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_done_i || rsp_done_i) |-> !issue_ok_o);

    // R10: an open line stays open while no strobe arrives.
    assert_stays_open_R10: assert property (@(posedge clk) disable iff (rst)
        (issue_ok_o && !cmd_done_i && !rsp_done_i) |=> issue_ok_o || cmd_done_i || rsp_done_i);

endmodule

// File: tb/cmdgap_top_tb.sv
`timescale 1ns/1ps
module cmdgap_top_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_done_i = 1'b0;
    logic rsp_done_i = 1'b0;
    logic no_rsp_i = 1'b0;
    logic acq_silent_i = 1'b0;
    logic issue_ok_o;

    int applied = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cmdgap_top u_dut (
        .clk          (clk),
        .rst          (rst),
        .cmd_done_i   (cmd_done_i),
        .rsp_done_i   (rsp_done_i),
        .no_rsp_i     (no_rsp_i),
        .acq_silent_i (acq_silent_i),
        .issue_ok_o   (issue_ok_o)
    );

    typedef struct packed {
        logic       cmd;
        logic       rsp;
        logic       quiet;
        logic       silent;
        logic [7:0] gap;
    } vec_t;

    // R3, R4, R5, R8, R9 with the default gaps (8, 8, 136).
    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 1'b1, 1'b0, 8'd8},    // R4 quiet command
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'd144},  // R5 silent identification
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'd8},    // R3 response end
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'd8},    // R9 silent flag on response
        '{1'b0, 1'b1, 1'b1, 1'b1, 8'd8},    // R9 both flags on response
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'd144},  // R8 command outranks response
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'd8}     // R8 quiet command with response
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        applied++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        cmd_done_i   = 1'b0;
        rsp_done_i   = 1'b0;
        no_rsp_i     = 1'b0;
        acq_silent_i = 1'b0;
    endtask

    // Drive one strobe cycle, then measure how many cycles the line stays closed
    // counting the strobe cycle itself.
    task automatic strobe_and_measure(input logic c, input logic r, input logic q,
                                      input logic s, input int exp, input string tag);
        int low;
        @(negedge clk);
        cmd_done_i = c; rsp_done_i = r; no_rsp_i = q; acq_silent_i = s;
        #1;
        check(issue_ok_o == 1'b0, "R2 closed during strobe", int'(issue_ok_o), 0);
        low = 1;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            clear_inputs();
            #1;
            if (issue_ok_o) break;
            low++;
        end
        check(low == exp, tag, low, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(issue_ok_o == 1'b1, "R1 open after reset", int'(issue_ok_o), 1);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            strobe_and_measure(VECS[i].cmd, VECS[i].rsp, VECS[i].quiet,
                               VECS[i].silent, int'(VECS[i].gap), "R3/R4/R5/R8/R9 gap");
        end

        // R10: idle line stays open
        begin
            int still_open;
            still_open = 1;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                #1;
                if (!issue_ok_o) still_open = 0;
            end
            check(still_open == 1, "R10 open while idle", still_open, 1);
        end

        // R6 + R9: command expecting a reply (silent flag set, ignored) holds the line
        begin
            int opened;
            opened = 0;
            @(negedge clk);
            cmd_done_i = 1'b1; no_rsp_i = 1'b0; acq_silent_i = 1'b1;
            for (int k = 0; k < 200; k++) begin
                @(negedge clk);
                clear_inputs();
                #1;
                if (issue_ok_o) opened = 1;
            end
            check(opened == 0, "R6 closed while reply awaited", opened, 0);
            strobe_and_measure(1'b0, 1'b1, 1'b0, 1'b0, 8, "R6 reply then response gap");
        end

        // R7: response end midway through the long silent window restarts at 8
        begin
            int low;
            @(negedge clk);
            cmd_done_i = 1'b1; no_rsp_i = 1'b1; acq_silent_i = 1'b1;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                clear_inputs();
            end
            #1;
            check(issue_ok_o == 1'b0, "R5 still closed mid window", int'(issue_ok_o), 0);
            strobe_and_measure(1'b0, 1'b1, 1'b0, 1'b0, 8, "R7 restart with newest rule");

            // R7: quiet command during a short gap switches to the long silent rule
            @(negedge clk);
            rsp_done_i = 1'b1;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                clear_inputs();
            end
            strobe_and_measure(1'b1, 1'b0, 1'b1, 1'b1, 144, "R7 restart to long gap");
            low = 0;
        end

        // R1: reset in the middle of a long window reopens the line
        @(negedge clk);
        cmd_done_i = 1'b1; no_rsp_i = 1'b1; acq_silent_i = 1'b1;
        @(negedge clk);
        clear_inputs();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(issue_ok_o == 1'b1, "R1 open after mid-window reset", int'(issue_ok_o), 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

endmodule